// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus (I2C-style) with a 512-byte memory behind it. The bus lines SCL and SDA are oversampled by a faster system clock, pass through synchronisers, and feed a protocol engine. The engine detects start and stop conditions, checks the address byte against a fixed type code and two strap inputs, and then writes data to the internal array or streams data out of it. SDA is never driven high. The block drives only an output enable that pulls the line low.

The address byte also carries a page bit, which becomes bit 8 of the 9-bit memory address. A write transaction sends the low 8 address bits after the address byte, followed by data bytes. A read transaction either follows such a word address after a repeated start, or begins at the internal address counter. A start or stop condition at any point abandons the operation in progress. A data byte that has not fully arrived is never stored.

Top module: `twm_slave`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. The slave responds only to an address byte that follows a start.
- R2: The address byte is sent MSB first. It is accepted only if bits 7:4 equal 4'b1010, bit 3 equals strap_i[1] and bit 2 equals strap_i[0]. Otherwise the slave does not acknowledge and stays idle until the next start. Bit 1 is the page bit. Bit 0 set to 1 means read and 0 means write.
- R3: For every byte it receives, the slave holds sda_oe_o high during the 9th SCL clock of that byte. This covers the accepted address byte, the word address and each data byte.
- R4: In a write, the byte after the address byte supplies address bits 7:0 and the page bit supplies bit 8. Each following data byte is stored at the current address on its acknowledge clock.
- R5: In a read, the slave sends each byte MSB first and goes on to the next byte while the master acknowledges. When the master does not acknowledge, the slave releases SDA and waits for a start.
- R6: The address counter advances by one after each data byte written or sent, and it wraps from 511 to 0.
- R7: A start received at any time aborts the current operation, discards any partly received byte, and makes the slave ready for a new address byte.
- R8: A stop aborts the current operation. Bus clocks that follow it without a new start are ignored and receive no acknowledge.
- R9: A read with no word address in the same transaction starts at the current counter's bits 7:0, with the page bit of the address byte as bit 8.
- R10: After reset, sda_oe_o is low and the slave is idle.
- R11: sda_oe_o goes high only while SCL is low. It goes low only while SCL is low, or on a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 2 | Device select straps compared with address bits 3:2 |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench uses the default parameters: type code 4'b1010, two synchroniser stages, and the full 9-bit address space. It ties the straps to 2'b10 and runs each SCL half-period as eight system clocks, which leaves room for the synchroniser delay. Because the whole space is addressable, writes and reads can cross the 511-to-0 boundary. The page bit takes effect both with and without a word address. Address bytes with a wrong type code and with wrong straps are both sent. Aborts are exercised by a start and by a stop issued in the middle of a data byte.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W + 1;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } twm_state_e;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
  parameter int         WIDTH   = 2,
  parameter int         STAGES  = 2,
  parameter logic [1:0] RST_VAL = 2'b11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= WIDTH'(RST_VAL);
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/twm_cond.sv
module twm_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = !scl_q && scl_s_i;
  assign scl_fall_o = scl_q && !scl_s_i;
  // SDA edge with SCL high in both samples
  assign start_o    = scl_q && scl_s_i && sda_q && !sda_s_i;
  assign stop_o     = scl_q && scl_s_i && !sda_q && sda_s_i;
endmodule

// File: rtl/twm_mem.sv
module twm_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/twm_engine.sv
module twm_engine
  import twm_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_s_i,
  input  logic [1:0]        strap_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              sda_oe_o,
  output twm_state_e        st_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(BYTE_W + 1);

  twm_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic              oe_q;
  logic              dev_match;
  logic [2:0]        tx_idx;

  assign dev_match = (sh_q[7:4] == TYPE_CODE) && (sh_q[3:2] == strap_i);
  assign tx_idx    = (cnt_q == CNT_DONE) ? 3'd7 : 3'(4'd7 - cnt_q);

  // commit on the acknowledge clock only; aborted bytes never reach here
  assign mem_we_o    = (st_q == ST_WDATA) && scl_rise_i && (cnt_q == CNT_ACK)
                       && !start_i && !stop_i;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = sh_q;
  assign sda_oe_o    = oe_q;
  assign st_o        = st_q;
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      oe_q   <= 1'b0;
    end else if (start_i) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise_i) begin
        if (cnt_q < CNT_ACK) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
          cnt_q <= cnt_q + 1'b1;
        end else if (cnt_q == CNT_ACK) begin
          cnt_q <= CNT_DONE;
          if (st_q == ST_WDATA) addr_q <= addr_q + 1'b1;
          if (st_q == ST_RDATA) begin
            addr_q <= addr_q + 1'b1;
            if (sda_s_i) begin
              st_q  <= ST_IDLE;
              cnt_q <= '0;
            end
          end
        end
      end else if (scl_fall_i) begin
        if (cnt_q == CNT_ACK) begin
          unique case (st_q)
            ST_DEV: begin
              if (dev_match) begin
                oe_q             <= 1'b1;
                addr_q[ADDR_W-1] <= sh_q[1];
              end else begin
                st_q  <= ST_IDLE;
                cnt_q <= '0;
              end
            end
            ST_WADDR: begin
              oe_q                <= 1'b1;
              addr_q[BYTE_W-1:0] <= sh_q;
            end
            ST_WDATA: oe_q <= 1'b1;
            ST_RDATA: oe_q <= 1'b0;
            default:  oe_q <= 1'b0;
          endcase
        end else if (cnt_q == CNT_DONE) begin
          cnt_q <= '0;
          unique case (st_q)
            ST_DEV: begin
              if (sh_q[0]) begin
                st_q <= ST_RDATA;
                oe_q <= !rd_data_i[tx_idx];
              end else begin
                st_q <= ST_WADDR;
                oe_q <= 1'b0;
              end
            end
            ST_WADDR: begin
              st_q <= ST_WDATA;
              oe_q <= 1'b0;
            end
            ST_WDATA: oe_q <= 1'b0;
            ST_RDATA: oe_q <= !rd_data_i[tx_idx];
            default:  oe_q <= 1'b0;
          endcase
        end else if (st_q == ST_RDATA && cnt_q != '0) begin
          oe_q <= !rd_data_i[tx_idx];
        end
      end
    end
  end
endmodule

// File: rtl/twm_slave.sv
module twm_slave
  import twm_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE   = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe_o
);
  logic [1:0]        bus_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;
  twm_state_e        eng_st;
  logic [CNT_W-1:0]  eng_cnt;

  twm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  twm_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (bus_s[1]),
    .sda_s_i   (bus_s[0]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  twm_engine #(.TYPE_CODE(TYPE_CODE)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_s_i    (bus_s[0]),
    .strap_i    (strap_i),
    .rd_data_i  (mem_rdata),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_wdata_o(mem_wdata),
    .sda_oe_o   (sda_oe_o),
    .st_o       (eng_st),
    .cnt_o      (eng_cnt)
  );

  twm_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .addr_i (mem_addr),
    .wdata_i(mem_wdata),
    .rdata_o(mem_rdata)
  );
endmodule

// File: rtl/twm_slave_chk.sv
module twm_slave_chk
  import twm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              start_i,
  input logic              stop_i,
  input twm_state_e        st_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              oe_i
);
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_i) |-> !scl_i); // R11
  AST_OE_FALL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_i) |-> (!scl_i || $past(start_i || stop_i))); // R11
  AST_START_TO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_i == ST_DEV && cnt_i == '0 && !oe_i)); // R7
  AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_i == ST_IDLE && !oe_i)); // R8
  AST_WRITE_WHILE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> oe_i); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (addr_i == ADDR_W'($past(addr_i) + 1'b1))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !oe_i); // R5
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(BYTE_W + 1)); // R3
endmodule

bind twm_slave twm_slave_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .scl_i  (scl_i),
  .start_i(start_det),
  .stop_i (stop_det),
  .st_i   (eng_st),
  .cnt_i  (eng_cnt),
  .we_i   (mem_we),
  .addr_i (mem_addr),
  .oe_i   (sda_oe_o)
);

// File: tb/twm_slave_bench.sv
module twm_slave_bench;
  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 8;
  localparam logic [1:0] STRAP      = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  int   oe_bad = 0;
  logic oe_prev = 1'b0;

  logic [7:0] exp_mem [512];
  int         m_addr = 0;
  logic [7:0] exp_q [$];
  string      req_q [$];
  logic [7:0] rx_byte;
  int         rx_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twm_slave u_twm_slave (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .strap_i (STRAP),
    .sda_oe_o(sda_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic page, input logic rd);
    return {4'b1010, STRAP, page, rd};
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q/2);
    b = sda_bus;  tick(Q/2);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(x);
    ack = !x;
  endtask

  task automatic recv_byte(input bit mack);
    logic [7:0] b;
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      b[i] = x;
    end
    rx_byte = b;
    rx_cnt++;
    put_bit(!mack);
  endtask

  task automatic write_burst(input logic page, input logic [7:0] wa, input int n,
                             input logic [7:0] base, input logic [7:0] step);
    bit ack;
    int a;
    i2c_start();
    send_byte(dev(page, 1'b0), ack);
    check(ack, "R1", "address ack after start", ack, 1);
    send_byte(wa, ack);
    check(ack, "R3", "word address ack", ack, 1);
    a = {page, wa};
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = base + 8'(i) * step;
      send_byte(d, ack);
      check(ack, "R3", "data ack", ack, 1);
      exp_mem[a] = d;
      a = (a + 1) % 512;
    end
    i2c_stop();
    m_addr = a;
  endtask

  task automatic read_burst(input logic page, input logic [7:0] wa, input bit use_wa,
                            input int n, input string req);
    bit ack;
    int a;
    if (use_wa) begin
      i2c_start();
      send_byte(dev(page, 1'b0), ack);
      check(ack, req, "dummy write address ack", ack, 1);
      send_byte(wa, ack);
      check(ack, req, "dummy word address ack", ack, 1);
      a = {page, wa};
    end else begin
      a = {page, 8'(m_addr)};
    end
    i2c_start();
    send_byte(dev(page, 1'b1), ack);
    check(ack, req, "read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp_mem[a]);
      req_q.push_back(req);
      recv_byte(i < n - 1);
      a = (a + 1) % 512;
    end
    tick(2);
    check(sda_oe === 1'b0, "R5", "SDA released after master nack", sda_oe, 0);
    i2c_stop();
    m_addr = a;
  endtask

  // scoreboard monitor: compares each byte the design shifts out
  initial begin
    forever begin
      @(rx_cnt);
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected read byte", rx_byte, 0);
      end else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(rx_byte === e, r, "read byte", rx_byte, e);
      end
    end
  end

  // R11: enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe !== oe_prev)) oe_bad++;
    oe_prev = sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    tick(5);
    check(sda_oe === 1'b0, "R10", "enable during reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    check(sda_oe === 1'b0, "R10", "enable after reset", sda_oe, 0);

    // R6: write across the 511 -> 0 boundary
    write_burst(1'b1, 8'hFE, 4, 8'hAA, 8'h11);
    write_burst(1'b0, 8'h10, 5, 8'h30, 8'h07);
    write_burst(1'b1, 8'h02, 1, 8'h5A, 8'h00);
    write_burst(1'b0, 8'h21, 1, 8'h77, 8'h00);
    write_burst(1'b0, 8'h31, 1, 8'h66, 8'h00);

    read_burst(1'b0, 8'h10, 1'b1, 5, "R4/R5");
    read_burst(1'b1, 8'hFE, 1'b1, 3, "R6");
    // R9: current-address reads, page from the address byte
    read_burst(1'b0, 8'h00, 1'b0, 1, "R9");
    read_burst(1'b1, 8'h00, 1'b0, 1, "R9");

    // R2: wrong type code, then wrong straps
    i2c_start();
    send_byte({4'b1011, STRAP, 2'b00}, ack);
    check(!ack, "R2", "type code mismatch acked", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte({4'b1010, ~STRAP, 2'b00}, ack);
    check(!ack, "R2", "strap mismatch acked", ack, 0);
    i2c_stop();

    // R7: partial byte then repeated start
    i2c_start();
    send_byte(dev(1'b0, 1'b0), ack);
    send_byte(8'h20, ack);
    send_byte(8'h11, ack);
    exp_mem[9'h020] = 8'h11;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    i2c_start();
    send_byte(dev(1'b0, 1'b0), ack);
    check(ack, "R7", "new address after abort", ack, 1);
    i2c_stop();
    read_burst(1'b0, 8'h20, 1'b1, 2, "R7");

    // R8: partial byte then stop, then clocks without start
    i2c_start();
    send_byte(dev(1'b0, 1'b0), ack);
    send_byte(8'h30, ack);
    send_byte(8'h42, ack);
    exp_mem[9'h030] = 8'h42;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    i2c_stop();
    tick(Q);
    scl_m = 1'b0;
    tick(Q);
    send_byte(8'h55, ack);
    check(!ack, "R8", "byte after stop acked", ack, 0);
    i2c_stop();
    read_burst(1'b0, 8'h30, 1'b1, 2, "R8");

    tick(4 * Q);
    check(exp_q.size() == 0, "R5", "bytes left unread", exp_q.size(), 0);
    check(oe_bad == 0, "R11", "enable changes with SCL high", oe_bad, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule